// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds two small per-CPU interrupt vectors for a system of up to four processors: one pending bit per CPU for inter-processor interrupts (IPIs) and one per CPU for the periodic timer. Software reaches it through a 64-bit register bus. A write to the control register can post IPIs, clear IPIs and clear timer interrupts in a single access, because each action has its own 4-bit CPU mask field. Three further registers each take a single CPU mask in their low bits and do one of these actions. A tick input from an external timer marks a timer interrupt pending for every CPU. The pending vectors drive the per-CPU `ipi_o` and `timer_o` lines directly.

Reads are combinational. A read of the control register returns both pending vectors together with the identifier of the CPU that issued the read. Three one-cycle status pulses report the unusual cases. One marks a post to a CPU whose IPI is already pending. One marks a clear of a CPU that has no IPI pending. One marks an illegal access, which changes no state.

The register index is taken from address bits 4:3. Index 0 is the control register, 1 is the IPI state register (a write clears), 2 is the timer state register (a write clears), and 3 is the IPI request register (a write posts; a read returns zero).

Top module: `ipi_timer_irq_ctrl`

## Requirements
- R1: After reset, every bit of `ipi_o` and `timer_o` is 0 and all three status pulses are low.
- R2: A write to the control register (index 0) posts an IPI to each CPU whose bit is set in wdata[15:12], and clears the IPI of each CPU whose bit is set in wdata[11:8]. Posting is applied first, so a CPU named in both fields ends up cleared. The change is visible on `ipi_o` one clock after the write.
- R3: In a control write, each set bit of wdata[7:4] clears the timer interrupt of that CPU.
- R4: A cycle with `tick_i` high sets the timer bit of every CPU. If a timer clear for a CPU arrives in the same cycle, the tick wins and the bit stays set.
- R5: A write to index 3 posts IPIs from wdata[3:0]. A write to index 1 clears IPIs from wdata[3:0]. A write to index 2 clears timer bits from wdata[3:0]. A read of index 1 returns the IPI vector in bits 3:0, a read of index 2 returns the timer vector in bits 3:0, and a read of index 3 returns zero.
- R6: A read of the control register returns the IPI vector in bits 11:8, the timer vector in bits 7:4 and `req_cpu_i` in bits 1:0. All other bits are zero.
- R7: `post_warn_o` pulses in the cycle after a write that posts to a CPU whose IPI is already pending. That CPU stays pending.
- R8: `clr_warn_o` pulses in the cycle after a write that clears the IPI of a CPU that has no IPI pending once that write's posts are applied.
- R9: `illegal_o` pulses in the cycle after either of two writes, and neither changes any state. One is a control write whose bits 15:4 and bit 28 are all zero. The other is a write to index 1, 2 or 3 whose wdata[3:0] is zero.
- R10: A control write with only bit 28 set (memory-error acknowledge) is accepted. It changes no state and raises no status pulse.
- R11: Each status pulse lasts one cycle per triggering write and appears only in the cycle after a bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Periodic timer tick, one cycle |
| req_valid_i | input | 1 | Bus request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte address; bits 4:3 select the register |
| req_wdata_i | input | 64 | Write data |
| req_cpu_i | input | 2 | Identifier of the requesting CPU |
| rdata_o | output | 64 | Read data, combinational, zero when not reading |
| ipi_o | output | 4 | Per-CPU pending IPI |
| timer_o | output | 4 | Per-CPU pending timer interrupt |
| post_warn_o | output | 1 | Post to an already pending IPI |
| clr_warn_o | output | 1 | Clear of a non-pending IPI |
| illegal_o | output | 1 | Illegal access rejected |

## Verification
The control register is written with single-field values and with multi-field values. Single-field writes separate the post, IPI-clear and timer-clear paths. A value that posts and clears the same CPU exposes the order in which the two are applied. A partly overlapping post and a repeated clear show that a warning leaves the other CPUs' updates intact. Tick alone is distinguished from tick combined with a same-cycle clear. The dedicated registers are exercised with masks that differ from the control-field masks, and the reads check the bit placement. Zero masks and the lone acknowledge bit separate rejected writes from accepted no-op writes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    REG_CTRL     = 2'd0,
    REG_IPI_STAT = 2'd1,
    REG_TMR_STAT = 2'd2,
    REG_IPI_REQ  = 2'd3
  } reg_sel_e;

  localparam int unsigned SEL_W       = 2;
  localparam int unsigned POST_LSB    = 12;
  localparam int unsigned IPI_CLR_LSB = 8;
  localparam int unsigned TMR_CLR_LSB = 4;
  localparam int unsigned MEMERR_BIT  = 28;
  localparam int unsigned RD_IPI_LSB  = 8;
  localparam int unsigned RD_TMR_LSB  = 4;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned SEL_LSB = 3
) (
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  output reg_sel_e             sel_o,
  output logic [NUM_CPU-1:0]   post_o,
  output logic [NUM_CPU-1:0]   ipi_clr_o,
  output logic [NUM_CPU-1:0]   tmr_clr_o,
  output logic                 illegal_o
);
  logic [NUM_CPU-1:0] f_post, f_iclr, f_tclr, f_low;
  logic               wr;
  logic               unused_bits;

  assign unused_bits = ^{req_addr_i, req_wdata_i};
  assign sel_o  = reg_sel_e'(req_addr_i[SEL_LSB +: SEL_W]);
  assign wr     = req_valid_i && req_write_i;
  assign f_post = req_wdata_i[POST_LSB +: NUM_CPU];
  assign f_iclr = req_wdata_i[IPI_CLR_LSB +: NUM_CPU];
  assign f_tclr = req_wdata_i[TMR_CLR_LSB +: NUM_CPU];
  assign f_low  = req_wdata_i[NUM_CPU-1:0];

  always_comb begin
    post_o    = '0;
    ipi_clr_o = '0;
    tmr_clr_o = '0;
    illegal_o = 1'b0;
    if (wr) begin
      unique case (sel_o)
        REG_CTRL: begin
          if (f_post == '0 && f_iclr == '0 && f_tclr == '0 && !req_wdata_i[MEMERR_BIT]) begin
            illegal_o = 1'b1;
          end else begin
            post_o    = f_post;
            ipi_clr_o = f_iclr;
            tmr_clr_o = f_tclr;
          end
        end
        REG_IPI_STAT: if (f_low == '0) illegal_o = 1'b1; else ipi_clr_o = f_low;
        REG_TMR_STAT: if (f_low == '0) illegal_o = 1'b1; else tmr_clr_o = f_low;
        REG_IPI_REQ:  if (f_low == '0) illegal_o = 1'b1; else post_o    = f_low;
        default: illegal_o = 1'b1;
      endcase
    end
  end

  // R9
  always_comb begin
    no_effect_when_illegal_chk: assert (!illegal_o || (post_o == '0 && ipi_clr_o == '0 && tmr_clr_o == '0));
  end
endmodule

// File: rtl/ipi_state.sv
module ipi_state #(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CPU-1:0] post_i,
  input  logic [NUM_CPU-1:0] clr_i,
  output logic [NUM_CPU-1:0] ipi_o,
  output logic               post_warn_o,
  output logic               clr_warn_o
);
  logic [NUM_CPU-1:0] ipi_q, posted;

  assign posted      = ipi_q | post_i;
  assign post_warn_o = |(post_i & ipi_q);
  assign clr_warn_o  = |(clr_i & ~posted);
  assign ipi_o       = ipi_q;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ipi_q[c] <= 1'b0;
      else if (clr_i[c]) ipi_q[c] <= 1'b0;
      else if (post_i[c]) ipi_q[c] <= 1'b1;
    end
  end

  // R2
  ipi_post_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(post_i & ~clr_i)) |=> ((ipi_q & $past(post_i & ~clr_i)) == $past(post_i & ~clr_i)));
  // R2
  ipi_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((ipi_q & $past(clr_i)) == '0));
  // R9
  ipi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_i == '0 && clr_i == '0) |=> $stable(ipi_q));
endmodule

// File: rtl/tmr_state.sv
module tmr_state #(
  parameter int unsigned NUM_CPU = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [NUM_CPU-1:0] clr_i,
  output logic [NUM_CPU-1:0] tmr_o
);
  logic [NUM_CPU-1:0] tmr_q;

  assign tmr_o = tmr_q;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       tmr_q[c] <= 1'b0;
      else if (tick_i)   tmr_q[c] <= 1'b1;
      else if (clr_i[c]) tmr_q[c] <= 1'b0;
    end
  end

  // R4
  tick_sets_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (&tmr_q));
  // R3
  tmr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && (|clr_i)) |=> ((tmr_q & $past(clr_i)) == '0));
endmodule

// File: rtl/ipi_timer_irq_ctrl.sv
module ipi_timer_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned SEL_LSB = 3,
  localparam int unsigned CPU_ID_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  input  logic [CPU_ID_W-1:0] req_cpu_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [NUM_CPU-1:0]  ipi_o,
  output logic [NUM_CPU-1:0]  timer_o,
  output logic                post_warn_o,
  output logic                clr_warn_o,
  output logic                illegal_o
);
  reg_sel_e           sel;
  logic [NUM_CPU-1:0] post, ipi_clr, tmr_clr;
  logic               illegal, post_warn, clr_warn;
  logic               post_warn_q, clr_warn_q, illegal_q;

  irq_reg_decode #(
    .NUM_CPU(NUM_CPU), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB)
  ) i_decode (
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_addr_i (req_addr_i),
    .req_wdata_i(req_wdata_i),
    .sel_o      (sel),
    .post_o     (post),
    .ipi_clr_o  (ipi_clr),
    .tmr_clr_o  (tmr_clr),
    .illegal_o  (illegal)
  );

  ipi_state #(.NUM_CPU(NUM_CPU)) i_ipi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .post_i     (post),
    .clr_i      (ipi_clr),
    .ipi_o      (ipi_o),
    .post_warn_o(post_warn),
    .clr_warn_o (clr_warn)
  );

  tmr_state #(.NUM_CPU(NUM_CPU)) i_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .clr_i (tmr_clr),
    .tmr_o (timer_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      post_warn_q <= 1'b0;
      clr_warn_q  <= 1'b0;
      illegal_q   <= 1'b0;
    end else begin
      post_warn_q <= post_warn;
      clr_warn_q  <= clr_warn;
      illegal_q   <= illegal;
    end
  end

  assign post_warn_o = post_warn_q;
  assign clr_warn_o  = clr_warn_q;
  assign illegal_o   = illegal_q;

  always_comb begin
    rdata_o = '0;
    if (req_valid_i && !req_write_i) begin
      unique case (sel)
        REG_CTRL: begin
          rdata_o[RD_IPI_LSB +: NUM_CPU] = ipi_o;
          rdata_o[RD_TMR_LSB +: NUM_CPU] = timer_o;
          rdata_o[CPU_ID_W-1:0]          = req_cpu_i;
        end
        REG_IPI_STAT: rdata_o[NUM_CPU-1:0] = ipi_o;
        REG_TMR_STAT: rdata_o[NUM_CPU-1:0] = timer_o;
        default:      rdata_o = '0;
      endcase
    end
  end

  // R11
  pulse_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_warn_o || clr_warn_o || illegal_o) |-> $past(req_valid_i && req_write_i));
  // R9
  illegal_keeps_ipi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $stable(ipi_o));
  // R7
  post_warn_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_warn |=> ((ipi_o & $past(ipi_o)) == $past(ipi_o & ~ipi_clr)));
endmodule

// File: tb/test_ipi_timer_irq_ctrl.sv
module test_ipi_timer_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  req_cpu = '0;
  logic [63:0] rdata;
  logic [3:0]  ipi, timer;
  logic        post_warn, clr_warn, illegal;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_timer_irq_ctrl i_ipi_timer_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_cpu_i(req_cpu), .rdata_o(rdata),
    .ipi_o(ipi), .timer_o(timer), .post_warn_o(post_warn),
    .clr_warn_o(clr_warn), .illegal_o(illegal)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // write with optional same-cycle tick; outputs sampled at the following negedge
  task automatic wr(input logic [1:0] idx, input logic [63:0] data, input logic with_tick);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    req_addr = {3'b0, idx, 3'b0}; req_wdata = data; tick = with_tick;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, input logic [1:0] cpu, output logic [63:0] val);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {3'b0, idx, 3'b0}; req_cpu = cpu;
    #1 val = rdata;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk_flags(input string req, input logic pw, input logic cw, input logic il);
    chk({req, " post_warn"}, 64'(post_warn), 64'(pw));
    chk({req, " clr_warn"},  64'(clr_warn),  64'(cw));
    chk({req, " illegal"},   64'(illegal),   64'(il));
  endtask

  task automatic t_reset();
    chk("R1 ipi", 64'(ipi), 64'h0);
    chk("R1 timer", 64'(timer), 64'h0);
    chk_flags("R1", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_ctrl_post();
    logic [63:0] v;
    wr(2'd0, 64'h5000, 1'b0);
    chk("R2 post cpu0,2", 64'(ipi), 64'h5);
    chk_flags("R2", 1'b0, 1'b0, 1'b0);
    rd(2'd0, 2'd3, v);
    chk("R6 ctrl read", v, 64'h503);
    wr(2'd0, 64'h3000, 1'b0);
    chk("R7 partial repost", 64'(ipi), 64'h7);
    chk_flags("R7", 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R11 post_warn single cycle", 64'(post_warn), 64'h0);
  endtask

  task automatic t_ctrl_clear();
    wr(2'd0, 64'h0300, 1'b0);
    chk("R2 clear cpu0,1", 64'(ipi), 64'h4);
    chk_flags("R2 clear", 1'b0, 1'b0, 1'b0);
    wr(2'd0, 64'h0100, 1'b0);
    chk("R8 clear idle cpu", 64'(ipi), 64'h4);
    chk_flags("R8", 1'b0, 1'b1, 1'b0);
    wr(2'd0, 64'h8800, 1'b0);
    chk("R2 post+clear same cpu", 64'(ipi), 64'h4);
    chk_flags("R2 post+clear", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_timer();
    logic [63:0] v;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R4 tick sets all", 64'(timer), 64'hF);
    rd(2'd0, 2'd1, v);
    chk("R6 ctrl read timer", v, 64'h4F1);
    wr(2'd0, 64'h0030, 1'b0);
    chk("R3 ctrl timer clear", 64'(timer), 64'hC);
    chk("R3 ipi untouched", 64'(ipi), 64'h4);
    wr(2'd2, 64'h4, 1'b1);
    chk("R4 tick beats clear", 64'(timer), 64'hF);
  endtask

  task automatic t_dedicated();
    logic [63:0] v;
    wr(2'd3, 64'h3, 1'b0);
    chk("R5 request reg", 64'(ipi), 64'h7);
    rd(2'd1, 2'd0, v);
    chk("R5 ipi read", v, 64'h7);
    wr(2'd1, 64'h6, 1'b0);
    chk("R5 ipi clear reg", 64'(ipi), 64'h1);
    wr(2'd2, 64'h9, 1'b0);
    chk("R5 timer clear reg", 64'(timer), 64'h6);
    rd(2'd2, 2'd0, v);
    chk("R5 timer read", v, 64'h6);
    rd(2'd3, 2'd2, v);
    chk("R5 request read zero", v, 64'h0);
  endtask

  task automatic t_illegal();
    wr(2'd0, 64'h000F, 1'b0);
    chk_flags("R9 empty ctrl", 1'b0, 1'b0, 1'b1);
    chk("R9 ipi kept", 64'(ipi), 64'h1);
    chk("R9 timer kept", 64'(timer), 64'h6);
    @(negedge clk);
    chk("R11 illegal single cycle", 64'(illegal), 64'h0);
    wr(2'd3, 64'h10, 1'b0);
    chk_flags("R9 zero request mask", 1'b0, 1'b0, 1'b1);
    chk("R9 ipi kept req", 64'(ipi), 64'h1);
    wr(2'd2, 64'h0, 1'b0);
    chk_flags("R9 zero timer mask", 1'b0, 1'b0, 1'b1);
    chk("R9 timer kept clr", 64'(timer), 64'h6);
  endtask

  task automatic t_memerr();
    wr(2'd0, 64'h1000_0000, 1'b0);
    chk_flags("R10 ack only", 1'b0, 1'b0, 1'b0);
    chk("R10 ipi", 64'(ipi), 64'h1);
    chk("R10 timer", 64'(timer), 64'h6);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_post();
    t_ctrl_clear();
    t_timer();
    t_dedicated();
    t_illegal();
    t_memerr();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule